// File: doc/BRIEF.md
# Memory-Mapped GPIO Port with Bit Set/Clear Registers

A general-purpose I/O port of 28 lines, numbered 0 to 27, attached to a plain memory-mapped register bus. Each line has a direction bit and an output latch bit. Software changes the output latch only through two write-only strobe registers. One register forces the written ones high and the other forces them low. A single bit can therefore be flipped without a read-modify-write sequence, which another bus master could otherwise race.

The pins enter through a two-flop synchronizer, and a read-only level register shows them. The level register reflects every line, whatever its direction. The port drives one output enable and one output value per line. The output value is always the latch, so a level preset while a line is still an input appears on the pin as soon as the line is made an output.

Bus accesses finish in one cycle. A write takes effect at the clock edge where `bus_sel` and `bus_wr` are both high. Read data is combinational from the addressed register while `bus_sel` is high and `bus_wr` is low.

Top module: `gpio_port_top`

## Requirements
- R1: After a synchronous reset, every line is an input and every latch bit is 0: `pin_oe` and `pin_out` are all zero, and the direction register reads zero.
- R2: A write to offset 0x08 (set) forces each latch bit whose data bit is 1 to 1 at that clock edge. Latch bits whose data bit is 0 keep their value.
- R3: A write to offset 0x0C (clear) forces each latch bit whose data bit is 1 to 0 at that clock edge. Latch bits whose data bit is 0 keep their value. If both registers target the same bit in one cycle, the clear wins.
- R4: Offset 0x04 holds the direction, where 1 means output and 0 means input. A write replaces the whole word, a read returns it, and `pin_oe` equals it from the cycle after the write.
- R5: The latch keeps its value across direction changes. `pin_out` always shows the latch, so a value preset while a line is an input is driven in the same cycle that `pin_oe` rises.
- R6: A read of offset 0x00 (level) returns `pin_in` as it was two rising edges earlier (a two-flop synchronizer), for input and output lines alike.
- R7: Bits 31 to 28 of every read are 0, and the set and clear offsets read as 0. Only address bits 3:2 select the register; bits 1:0 are ignored.
- R8: Only writes to the set and clear offsets change the latch. A write to the level offset and any read leave both the latch and the direction unchanged.
- R9: `bus_rdata` is 0 in any cycle without a read access (`bus_sel` low, or `bus_wr` high).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte offset (0x00, 0x04, 0x08, 0x0C) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, zero outside reads |
| pin_in | input | 28 | Asynchronous pin levels |
| pin_oe | output | 28 | Per-line output enable (direction) |
| pin_out | output | 28 | Per-line output value (latch) |

## Verification
The bench walks a single one across all 28 lines through the set register and then the clear register, and after each step it checks that no other latch bit moved. A design that treats these registers as plain stores would wipe the neighbouring bits at this point. Pseudo-random set and clear words check the latch against a model computed in the bench. The bench presets the latch while lines are inputs and then raises the direction, which catches a design that gates or resets the latch with the direction bit. It samples the level register one edge and two edges after a pin change, which exposes a synchronizer with the wrong depth. Writes to the level offset, partial address bits and the zero upper bits are each probed at the ports.

// File: rtl/gpx_pkg.sv
package gpx_pkg;

    localparam int unsigned GPX_LINES   = 28;
    localparam int unsigned GPX_DATA_W  = 32;
    localparam int unsigned GPX_ADDR_W  = 4;
    localparam int unsigned GPX_SYNC_N  = 2;

    // Register select taken from address bits 3:2.
    typedef enum logic [1:0] {
        GPX_REG_LEVEL = 2'd0,
        GPX_REG_DIR   = 2'd1,
        GPX_REG_SET   = 2'd2,
        GPX_REG_CLR   = 2'd3
    } gpx_reg_e;

    // One-hot write strobes, one per register.
    typedef struct packed {
        logic lvl;
        logic dir;
        logic set;
        logic clr;
    } gpx_wstb_t;

    // Read request carried to the read multiplexer.
    typedef struct packed {
        logic     en;
        gpx_reg_e sel;
    } gpx_rreq_t;

    function automatic gpx_reg_e gpx_reg_of(input logic [1:0] word_idx);
        return gpx_reg_e'(word_idx);
    endfunction

    // Next latch value. The clear mask is applied last, so clear wins over set.
    function automatic logic [GPX_LINES-1:0] gpx_latch_next(
        input logic [GPX_LINES-1:0] cur,
        input logic [GPX_LINES-1:0] set_m,
        input logic [GPX_LINES-1:0] clr_m
    );
        return (cur | set_m) & ~clr_m;
    endfunction

endpackage

// File: rtl/gpx_decode.sv
module gpx_decode
    import gpx_pkg::*;
#(
    parameter int unsigned ADDR_W = GPX_ADDR_W
) (
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    output gpx_wstb_t         wstb,
    output gpx_rreq_t         rreq
);
    localparam int unsigned IDX_LO = 2;
    localparam int unsigned IDX_HI = IDX_LO + 1;

    gpx_reg_e reg_sel;
    logic     unused_addr;

    assign reg_sel     = gpx_reg_of(bus_addr[IDX_HI:IDX_LO]);
    // Byte-lane bits and any bits above the register index play no part.
    assign unused_addr = ^{bus_addr[IDX_LO-1:0], bus_addr[ADDR_W-1:IDX_HI]};

    always_comb begin
        wstb = '0;
        if (bus_sel && bus_wr) begin
            unique case (reg_sel)
                GPX_REG_LEVEL: wstb.lvl = 1'b1;
                GPX_REG_DIR:   wstb.dir = 1'b1;
                GPX_REG_SET:   wstb.set = 1'b1;
                GPX_REG_CLR:   wstb.clr = 1'b1;
                default:       wstb     = '0;
            endcase
        end
    end

    always_comb begin
        rreq.en  = bus_sel && !bus_wr;
        rreq.sel = reg_sel;
    end

endmodule

// File: rtl/gpx_out_latch.sv
module gpx_out_latch
    import gpx_pkg::*;
#(
    parameter int unsigned NUM_LINES = GPX_LINES
) (
    input  logic                 clk,
    input  logic                 rst,
    input  gpx_wstb_t            wstb,
    input  logic [NUM_LINES-1:0] wdata,
    output logic [NUM_LINES-1:0] dir_q,
    output logic [NUM_LINES-1:0] lat_q
);
    logic [NUM_LINES-1:0] set_m;
    logic [NUM_LINES-1:0] clr_m;
    logic [NUM_LINES-1:0] lat_d;
    logic [NUM_LINES-1:0] dir_d;

    assign set_m = wstb.set ? wdata : '0;
    assign clr_m = wstb.clr ? wdata : '0;

    always_comb begin
        lat_d = (lat_q | set_m) & ~clr_m;
        dir_d = wstb.dir ? wdata : dir_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lat_q <= '0;
            dir_q <= '0;
        end else begin
            lat_q <= lat_d;
            dir_q <= dir_d;
        end
    end

endmodule

// File: rtl/gpx_in_sync.sv
module gpx_in_sync
    import gpx_pkg::*;
#(
    parameter int unsigned NUM_LINES = GPX_LINES,
    parameter int unsigned STAGES    = GPX_SYNC_N
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_LINES-1:0] pin_async,
    output logic [NUM_LINES-1:0] pin_sync
);
    genvar g;
    generate
        for (g = 0; g < NUM_LINES; g++) begin : g_line
            logic [STAGES-1:0] chain;
            always_ff @(posedge clk) begin
                if (rst) begin
                    chain <= '0;
                end else begin
                    chain <= {chain[STAGES-2:0], pin_async[g]};
                end
            end
            assign pin_sync[g] = chain[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/gpx_read_mux.sv
module gpx_read_mux
    import gpx_pkg::*;
#(
    parameter int unsigned NUM_LINES = GPX_LINES,
    parameter int unsigned DATA_W    = GPX_DATA_W
) (
    input  gpx_rreq_t            rreq,
    input  logic [NUM_LINES-1:0] level,
    input  logic [NUM_LINES-1:0] dir,
    output logic [DATA_W-1:0]    rdata
);
    localparam int unsigned PAD_W = DATA_W - NUM_LINES;

    always_comb begin
        rdata = '0;
        if (rreq.en) begin
            unique case (rreq.sel)
                GPX_REG_LEVEL: rdata = {{PAD_W{1'b0}}, level};
                GPX_REG_DIR:   rdata = {{PAD_W{1'b0}}, dir};
                // The set and clear registers read as zero.
                default:       rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/gpio_port_top.sv
module gpio_port_top
    import gpx_pkg::*;
#(
    parameter int unsigned NUM_LINES   = GPX_LINES,
    parameter int unsigned DATA_W      = GPX_DATA_W,
    parameter int unsigned ADDR_W      = GPX_ADDR_W,
    parameter int unsigned SYNC_STAGES = GPX_SYNC_N
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bus_sel,
    input  logic                 bus_wr,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    input  logic [NUM_LINES-1:0] pin_in,
    output logic [NUM_LINES-1:0] pin_oe,
    output logic [NUM_LINES-1:0] pin_out
);
    gpx_wstb_t            wstb;
    gpx_rreq_t            rreq;
    logic [NUM_LINES-1:0] dir_q;
    logic [NUM_LINES-1:0] lat_q;
    logic [NUM_LINES-1:0] level_q;
    logic                 unused_wdata_hi;

    assign unused_wdata_hi = ^bus_wdata[DATA_W-1:NUM_LINES];

    gpx_decode #(
        .ADDR_W (ADDR_W)
    ) decode_i (
        .bus_sel  (bus_sel),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .wstb     (wstb),
        .rreq     (rreq)
    );

    gpx_out_latch #(
        .NUM_LINES (NUM_LINES)
    ) latch_i (
        .clk   (clk),
        .rst   (rst),
        .wstb  (wstb),
        .wdata (bus_wdata[NUM_LINES-1:0]),
        .dir_q (dir_q),
        .lat_q (lat_q)
    );

    gpx_in_sync #(
        .NUM_LINES (NUM_LINES),
        .STAGES    (SYNC_STAGES)
    ) sync_i (
        .clk       (clk),
        .rst       (rst),
        .pin_async (pin_in),
        .pin_sync  (level_q)
    );

    gpx_read_mux #(
        .NUM_LINES (NUM_LINES),
        .DATA_W    (DATA_W)
    ) rmux_i (
        .rreq  (rreq),
        .level (level_q),
        .dir   (dir_q),
        .rdata (bus_rdata)
    );

    assign pin_oe  = dir_q;
    assign pin_out = lat_q;

endmodule

// File: rtl/gpx_port_chk.sv
module gpx_port_chk #(
    parameter int unsigned NUM_LINES   = 28,
    parameter int unsigned DATA_W      = 32,
    parameter int unsigned ADDR_W      = 4,
    parameter int unsigned SYNC_STAGES = 2
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 bus_sel,
    input logic                 bus_wr,
    input logic [ADDR_W-1:0]    bus_addr,
    input logic [DATA_W-1:0]    bus_wdata,
    input logic [DATA_W-1:0]    bus_rdata,
    input logic [NUM_LINES-1:0] pin_in,
    input logic [NUM_LINES-1:0] pin_oe,
    input logic [NUM_LINES-1:0] pin_out
);
    logic       seen_rst;
    logic [1:0] since_rst;
    logic       wr_set;
    logic       wr_clr;
    logic       wr_dir;
    logic       rd_lvl;

    assign wr_set = bus_sel && bus_wr  && bus_addr[3:2] == 2'd2;
    assign wr_clr = bus_sel && bus_wr  && bus_addr[3:2] == 2'd3;
    assign wr_dir = bus_sel && bus_wr  && bus_addr[3:2] == 2'd1;
    assign rd_lvl = bus_sel && !bus_wr && bus_addr[3:2] == 2'd0;

    always_ff @(posedge clk) begin
        seen_rst <= rst;
        if (rst)
            since_rst <= '0;
        else if (since_rst != 2'd3)
            since_rst <= since_rst + 2'd1;
    end

    // R1
    always_ff @(posedge clk) begin
        if (seen_rst === 1'b1) begin
            reset_state_chk: assert (pin_oe == '0 && pin_out == '0);
        end
    end

    // R2
    set_bits_chk: assert property (@(posedge clk) disable iff (rst)
        wr_set |=> ((pin_out & $past(bus_wdata[NUM_LINES-1:0])) == $past(bus_wdata[NUM_LINES-1:0])));

    // R3
    clr_bits_chk: assert property (@(posedge clk) disable iff (rst)
        wr_clr |=> ((pin_out & $past(bus_wdata[NUM_LINES-1:0])) == '0));

    // R4
    dir_write_chk: assert property (@(posedge clk) disable iff (rst)
        wr_dir |=> (pin_oe == $past(bus_wdata[NUM_LINES-1:0])));

    // R8
    latch_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(wr_set || wr_clr) |=> $stable(pin_out));

    // R7
    upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
        bus_rdata[DATA_W-1:NUM_LINES] == '0);

    // R9
    idle_rdata_chk: assert property (@(posedge clk) disable iff (rst)
        !(bus_sel && !bus_wr) |-> bus_rdata == '0);

    generate
        if (SYNC_STAGES == 2) begin : g_two_stage
            // R6
            level_delay_chk: assert property (@(posedge clk) disable iff (rst)
                (rd_lvl && since_rst == 2'd3) |-> bus_rdata[NUM_LINES-1:0] == $past(pin_in, 2));
        end
    endgenerate

endmodule

bind gpio_port_top gpx_port_chk #(
    .NUM_LINES   (NUM_LINES),
    .DATA_W      (DATA_W),
    .ADDR_W      (ADDR_W),
    .SYNC_STAGES (SYNC_STAGES)
) chk_i (
    .clk       (clk),
    .rst       (rst),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pin_in    (pin_in),
    .pin_oe    (pin_oe),
    .pin_out   (pin_out)
);

// File: tb/gpio_port_top_tb_top.sv
`timescale 1ns/1ps
module gpio_port_top_tb_top;

    localparam int unsigned N      = 28;
    localparam logic [3:0]  A_LVL  = 4'h0;
    localparam logic [3:0]  A_DIR  = 4'h4;
    localparam logic [3:0]  A_SET  = 4'h8;
    localparam logic [3:0]  A_CLR  = 4'hC;
    localparam logic [31:0] LMASK  = 32'h0FFF_FFFF;

    logic          clk = 1'b0;
    logic          rst;
    logic          bus_sel;
    logic          bus_wr;
    logic [3:0]    bus_addr;
    logic [31:0]   bus_wdata;
    logic [31:0]   bus_rdata;
    logic [N-1:0]  pin_in;
    logic [N-1:0]  pin_oe;
    logic [N-1:0]  pin_out;

    int   n_run  = 0;
    int   n_fail = 0;
    logic done   = 1'b0;

    logic [31:0] exp_lat;
    logic [31:0] exp_dir;
    logic [31:0] rd;
    logic [31:0] lfsr;

    always #4 clk = ~clk;

    gpio_port_top dut_i (
        .clk       (clk),
        .rst       (rst),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pin_in    (pin_in),
        .pin_oe    (pin_oe),
        .pin_out   (pin_out)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel   = 1'b1;
        bus_wr    = 1'b1;
        bus_addr  = a;
        bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_sel   = 1'b0;
        bus_wr    = 1'b0;
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
        bus_sel  = 1'b1;
        bus_wr   = 1'b0;
        bus_addr = a;
        #1;
        d = bus_rdata;
        bus_sel  = 1'b0;
    endtask

    function automatic logic [31:0] lfsr_step(input logic [31:0] x);
        return {x[30:0], x[31] ^ x[21] ^ x[1] ^ x[0]};
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
        pin_in = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        check("R1 oe", {4'h0, pin_oe}, 32'd0);
        check("R1 out", {4'h0, pin_out}, 32'd0);
        bus_read(A_DIR, rd); check("R1 dir read", rd, 32'd0);

        // R7: set/clear read as zero
        bus_read(A_SET, rd); check("R7 set reads 0", rd, 32'd0);
        bus_read(A_CLR, rd); check("R7 clr reads 0", rd, 32'd0);

        // R9: no access -> zero
        #1; check("R9 idle rdata", bus_rdata, 32'd0);

        // R2: walking set, cumulative
        exp_lat = 32'd0;
        for (int i = 0; i < N; i++) begin
            bus_write(A_SET, 32'd1 << i);
            exp_lat = exp_lat | (32'd1 << i);
            check("R2 walk set", {4'h0, pin_out}, exp_lat);
        end
        // R3: walking clear
        for (int i = 0; i < N; i++) begin
            bus_write(A_CLR, 32'd1 << i);
            exp_lat = exp_lat & ~(32'd1 << i);
            check("R3 walk clear", {4'h0, pin_out}, exp_lat);
        end

        // R2 R3: pseudo-random patterns
        lfsr = 32'hACE1_2357;
        for (int k = 0; k < 40; k++) begin
            lfsr = lfsr_step(lfsr);
            bus_write(A_SET, lfsr);
            exp_lat = (exp_lat | lfsr) & LMASK;
            check("R2 random set", {4'h0, pin_out}, exp_lat);
            lfsr = lfsr_step(lfsr);
            bus_write(A_CLR, lfsr);
            exp_lat = exp_lat & ~lfsr & LMASK;
            check("R3 random clear", {4'h0, pin_out}, exp_lat);
        end

        // R4: direction walk and whole-word write
        for (int i = 0; i < N; i++) begin
            bus_write(A_DIR, 32'd1 << i);
            check("R4 oe walk", {4'h0, pin_oe}, 32'd1 << i);
        end
        bus_write(A_DIR, 32'hFFFF_FFFF);
        exp_dir = LMASK;
        check("R4 oe all", {4'h0, pin_oe}, exp_dir);
        bus_read(A_DIR, rd); check("R4 R7 dir read upper zero", rd, exp_dir);
        bus_read(4'h7, rd);  check("R7 addr bits 1:0 ignored", rd, exp_dir);

        // R5: preset latch while inputs, then switch to output
        bus_write(A_DIR, 32'd0);
        bus_write(A_CLR, 32'hFFFF_FFFF);
        bus_write(A_SET, 32'h0A5A_5C3C);
        exp_lat = 32'h0A5A_5C3C;
        check("R5 latch while input", {4'h0, pin_out}, exp_lat);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = A_DIR; bus_wdata = 32'h0F0F_00FF;
        @(posedge clk); #1;
        check("R5 oe rises", {4'h0, pin_oe}, 32'h0F0F_00FF);
        check("R5 value at once", {4'h0, pin_out}, exp_lat);
        @(negedge clk); bus_sel = 1'b0; bus_wr = 1'b0;
        bus_write(A_DIR, 32'd0);
        check("R5 latch kept", {4'h0, pin_out}, exp_lat);

        // R8: writes to level offset and reads have no effect
        bus_write(A_DIR, 32'h0000_FFFF);
        bus_write(A_LVL, 32'hFFFF_FFFF);
        check("R8 lvl write latch", {4'h0, pin_out}, exp_lat);
        check("R8 lvl write dir", {4'h0, pin_oe}, 32'h0000_FFFF);
        @(negedge clk);
        bus_read(A_SET, rd); bus_read(A_CLR, rd); bus_read(A_LVL, rd);
        @(posedge clk); @(negedge clk);
        check("R8 reads leave latch", {4'h0, pin_out}, exp_lat);

        // R6: two-edge synchronizer delay, independent of direction
        for (int k = 0; k < 12; k++) begin
            lfsr = lfsr_step(lfsr);
            @(negedge clk);
            bus_read(A_LVL, rd);
            pin_in = lfsr[N-1:0];
            @(posedge clk); @(negedge clk);
            bus_read(A_LVL, rd);
            check("R6 not after one edge", rd == {4'h0, pin_in} ? 32'd1 : 32'd0,
                  (k == 0 && pin_in == '0) ? 32'd1 : 32'd0);
            @(posedge clk); @(negedge clk);
            bus_read(A_LVL, rd);
            check("R6 after two edges", rd, {4'h0, pin_in});
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule